// File: doc/BRIEF.md
# Single-Wire Bus Master Sequencer

This block drives one open-drain data line on which a single master talks to one or more slave devices. On command it generates a bus reset and records whether any device answered with a presence response. It also issues single write-0, write-1 and read time slots. The block never drives the line high. It only asserts `line_low` to pull the line down, and an external pull-up restores the high level. The level seen on the line is fed back through `line_in`.

A caller presents an operation code on `cmd_op`, plus the bit to write on `cmd_wbit`, and strobes `cmd_start` for one cycle while `busy` is low. `busy` stays high until the whole sequence has finished, recovery time included. A one-cycle `done` pulse then marks the end. After a read slot, `rd_bit` holds the received bit. After a reset, `presence` holds the presence result. All timing is expressed in microseconds and scaled by the `CLK_PER_US` parameter.

Top module: `swire_master`

## Requirements
- R1: An operation code of 2'b00 starts a reset. `line_low` is asserted for exactly 500 µs, that is 500*CLK_PER_US cycles.
- R2: After the reset low phase, the line is released and `busy` stays high for a further 480 µs. `busy` is therefore high for 980*CLK_PER_US cycles for a reset.
- R3: `presence` is set to 1 when the synchronized line is low at 70 µs after the release, and cleared otherwise. It keeps that value through later write and read slots until the next reset.
- R4: An operation code of 2'b01 starts a write slot. With `cmd_wbit`=1 the line is held low for 6 µs. With `cmd_wbit`=0 it is held low for 60 µs.
- R5: Every write or read slot keeps `busy` high for exactly 70 µs, recovery included.
- R6: An operation code of 2'b10 starts a read slot. The line is held low for 6 µs, and `rd_bit` takes the synchronized line level sampled 15 µs after the slot starts: 0 when a device holds the line low, 1 when it is released.
- R7: A `cmd_start` that arrives while `busy` is high is ignored. A `cmd_start` with operation code 2'b11 is ignored and does not raise `busy` or drive the line.
- R8: `done` is a single-cycle pulse in the first cycle in which `busy` is low after an operation.
- R9: After reset, `busy`, `done`, `line_low`, `rd_bit` and `presence` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_start | input | 1 | One-cycle strobe that starts the operation on `cmd_op` |
| cmd_op | input | 2 | 00 reset, 01 write slot, 10 read slot, 11 no operation |
| cmd_wbit | input | 1 | Bit sent by a write slot |
| busy | output | 1 | High from start until the operation and its recovery have ended |
| done | output | 1 | One-cycle pulse at the end of an operation |
| rd_bit | output | 1 | Bit received by the last read slot |
| presence | output | 1 | Result of the last reset: 1 when a device answered |
| line_low | output | 1 | Pulls the bus line low when high |
| line_in | input | 1 | Sensed bus line level (asynchronous) |

## Verification
The hardest cases to produce are the two sample points. Presence is sampled inside a recovery window, and the read bit is sampled 15 µs into a slot. In both cases the result depends on another device pulling the line at the right moment, seen through a two-flop synchronizer. The bench models that device. It watches `line_low` for its release and for its start-of-slot edge, then pulls the line low inside a window around the expected sample point. The window is wide enough to absorb the synchronizer delay, and it can be switched off to give the opposite outcome. A start strobe is also fired deep inside a reset to show that it neither extends `busy` nor adds low time.

// File: rtl/swire_master.sv
module swire_master #(
  parameter int CLK_PER_US   = 100,
  parameter int RST_LOW_US   = 500,
  parameter int RST_REL_US   = 480,
  parameter int PRES_US      = 70,
  parameter int SLOT_US      = 70,
  parameter int W0_LOW_US    = 60,
  parameter int SHORT_LOW_US = 6,
  parameter int RD_SAMPLE_US = 15
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_start,
  input  logic [1:0] cmd_op,
  input  logic       cmd_wbit,
  output logic       busy,
  output logic       done,
  output logic       rd_bit,
  output logic       presence,
  output logic       line_low,
  input  logic       line_in
);
  localparam int RST_LOW_CYC = RST_LOW_US * CLK_PER_US;
  localparam int RST_REL_CYC = RST_REL_US * CLK_PER_US;
  localparam int PRES_CYC    = PRES_US * CLK_PER_US;
  localparam int SLOT_CYC    = SLOT_US * CLK_PER_US;
  localparam int W0_CYC      = W0_LOW_US * CLK_PER_US;
  localparam int SHORT_CYC   = SHORT_LOW_US * CLK_PER_US;
  localparam int RD_CYC      = RD_SAMPLE_US * CLK_PER_US;
  localparam int MAX_CYC     = (RST_LOW_CYC > RST_REL_CYC) ? RST_LOW_CYC : RST_REL_CYC;
  localparam int CW          = $clog2(MAX_CYC + 1);

  typedef enum logic [1:0] {S_IDLE, S_RLOW, S_RREL, S_SLOT} state_t;

  state_t        state;
  logic [CW-1:0] cnt;
  logic          is_read, wbit_q;
  logic          sync1, sync2;
  logic          start_ok;

  assign start_ok = cmd_start && (state == S_IDLE) && (cmd_op != 2'b11);
  assign busy     = (state != S_IDLE);
  assign line_low = (state == S_RLOW) ||
                    ((state == S_SLOT) &&
                     (cnt < ((!is_read && !wbit_q) ? CW'(W0_CYC) : CW'(SHORT_CYC))));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) {sync2, sync1} <= 2'b11;
    else        {sync2, sync1} <= {sync1, line_in};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      cnt      <= '0;
      is_read  <= 1'b0;
      wbit_q   <= 1'b0;
      done     <= 1'b0;
      rd_bit   <= 1'b0;
      presence <= 1'b0;
    end else begin
      done <= 1'b0;
      cnt  <= cnt + 1'b1;
      case (state)
        S_IDLE: begin
          cnt <= '0;
          if (start_ok) begin
            is_read <= (cmd_op == 2'b10);
            wbit_q  <= cmd_wbit;
            state   <= (cmd_op == 2'b00) ? S_RLOW : S_SLOT;
          end
        end
        S_RLOW:
          if (cnt == CW'(RST_LOW_CYC - 1)) begin
            state <= S_RREL;
            cnt   <= '0;
          end
        S_RREL: begin
          if (cnt == CW'(PRES_CYC)) presence <= ~sync2;
          if (cnt == CW'(RST_REL_CYC - 1)) begin
            state <= S_IDLE;
            done  <= 1'b1;
          end
        end
        S_SLOT: begin
          if (is_read && cnt == CW'(RD_CYC)) rd_bit <= sync2;
          if (cnt == CW'(SLOT_CYC - 1)) begin
            state <= S_IDLE;
            done  <= 1'b1;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assert_reset_drive_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_RLOW) |-> line_low);

  assert_release_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_RREL) |-> !line_low);

  assert_short_release_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_SLOT && (is_read || wbit_q) && cnt >= CW'(SHORT_CYC)) |-> !line_low);

  assert_busy_start_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_SLOT && cmd_start) |=> (state != S_RLOW));

  assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !line_low);
endmodule

// File: tb/swire_master_bench.sv
module swire_master_bench;
  localparam int CPU = 2;

  logic       clk = 0;
  logic       rst_n = 0;
  logic       cmd_start = 0;
  logic [1:0] cmd_op = 2'b11;
  logic       cmd_wbit = 0;
  logic       busy, done, rd_bit, presence, line_low, line_in;

  int tests = 0;
  int fails = 0;

  int dev_mode = 0;
  int rel_cnt = 1000, slot_cnt = 1000;
  logic ll_q = 0;
  logic dev_low;

  always #5 clk = ~clk;

  swire_master #(.CLK_PER_US(CPU)) u_swire_master (
    .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_op(cmd_op),
    .cmd_wbit(cmd_wbit), .busy(busy), .done(done), .rd_bit(rd_bit),
    .presence(presence), .line_low(line_low), .line_in(line_in)
  );

  always @(posedge clk) begin
    ll_q <= line_low;
    if (ll_q && !line_low) rel_cnt <= 0;
    else if (rel_cnt < 1000) rel_cnt <= rel_cnt + 1;
    if (!ll_q && line_low) slot_cnt <= 0;
    else if (slot_cnt < 1000) slot_cnt <= slot_cnt + 1;
  end

  assign dev_low = (dev_mode == 1 && rel_cnt >= 40 && rel_cnt < 200) ||
                   (dev_mode == 2 && slot_cnt < 60);
  assign line_in = ~(line_low | dev_low);

  task automatic check(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  int low_n, busy_n, done_n;

  task automatic run_op(input logic [1:0] op, input logic wb, input int mid_op);
    int k;
    low_n = 0; busy_n = 0; done_n = 0;
    @(negedge clk);
    cmd_op = op; cmd_wbit = wb; cmd_start = 1;
    @(negedge clk);
    cmd_start = 0;
    k = 0;
    while (!done && k < 5000) begin
      if (busy) busy_n++;
      if (line_low) low_n++;
      if (mid_op >= 0 && k == 100) begin
        cmd_op = mid_op[1:0]; cmd_start = 1;
      end else cmd_start = 0;
      k++;
      @(negedge clk);
    end
    cmd_start = 0;
    if (done) done_n++;
    @(negedge clk);
    if (done) done_n++;
  endtask

  localparam int NV = 6;
  localparam int V_OP[NV]   = '{0, 0, 1, 1, 2, 2};
  localparam int V_WB[NV]   = '{0, 0, 1, 0, 0, 0};
  localparam int V_DEV[NV]  = '{0, 1, 0, 0, 0, 2};
  localparam int V_LOW[NV]  = '{500*CPU, 500*CPU, 6*CPU, 60*CPU, 6*CPU, 6*CPU};
  localparam int V_BUSY[NV] = '{980*CPU, 980*CPU, 70*CPU, 70*CPU, 70*CPU, 70*CPU};
  localparam int V_RES[NV]  = '{0, 1, -1, -1, 1, 0};

  initial begin
    #(200000 * 10);
    fails++;
    $display("FAIL watchdog: got %0d expected %0d", 1, 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R9 busy", busy, 0);
    check("R9 done", done, 0);
    check("R9 line_low", line_low, 0);
    check("R9 rd_bit", rd_bit, 0);
    check("R9 presence", presence, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      dev_mode = V_DEV[i];
      run_op(V_OP[i][1:0], V_WB[i][0], -1);
      check(V_OP[i] == 0 ? "R1 reset low time" : "R4 R6 slot low time", low_n, V_LOW[i]);
      check(V_OP[i] == 0 ? "R2 reset busy time" : "R5 slot busy time", busy_n, V_BUSY[i]);
      check("R8 done pulse count", done_n, 1);
      if (V_OP[i] == 0) check("R3 presence", presence, V_RES[i]);
      if (V_OP[i] == 2) check("R6 read bit", rd_bit, V_RES[i]);
    end

    check("R3 presence held across slots", presence, 1);

    dev_mode = 0;
    run_op(2'b00, 0, 2);
    check("R7 reset low with mid start", low_n, 500*CPU);
    check("R7 reset busy with mid start", busy_n, 980*CPU);
    repeat (20) begin
      @(negedge clk);
      check("R7 no late slot", busy | line_low, 0);
    end

    @(negedge clk);
    cmd_op = 2'b11; cmd_start = 1;
    @(negedge clk);
    cmd_start = 0;
    repeat (5) begin
      check("R7 op 11 ignored", busy | line_low | done, 0);
      @(negedge clk);
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule